// File: doc/BRIEF.md
# Rotating Light Toggle Game

This block drives an eight-LED display whose pattern turns left one place at a time. The bit that leaves the top end comes back in at the bottom end. The turning speed is set by the switch byte present while reset is held. That byte is stored as the low half of a sixteen-bit increment, and a sixteen-bit delay accumulator adds it once per step. Each carry out of the accumulator's top bit produces one left rotation. A larger switch value at reset therefore gives a faster rotation, and moving the switches afterwards leaves the rate unchanged.

Once running, the same switches are the player's controls. On each step the current switch byte is XORed with the byte seen on the previous sample. Every position that moved, in either direction, flips the LED above it. After a flip the block enters a lockout. Switch sampling stops and the stored previous byte is frozen until the next rotation, which keeps contact bounce from being counted as extra moves. A flip also clears the upper half of the delay accumulator, so that a minimum interval passes before the pattern moves on.

Steps happen on clock edges where `stepEn` is high. Tie `stepEn` high for one step per clock, or drive it from a prescaler.

Top module: `rot_toggle_game`

## Requirements
- R1: While `rstN` is low at a clock edge, the display loads 8'h01 and the lockout clears. The switch byte is captured as the increment {8'h00, sw}, and the same byte is stored as the previous switch sample.
- R2: On an edge where `stepEn` is low, no state changes, and `leds` holds its value whatever the switches do.
- R3: On a step without an applied change, the increment is added to the 16-bit accumulator. When that addition carries out of bit 15, `leds` rotates left by one on the same edge: bit 7 moves to bit 0 and bit i moves to bit i+1.
- R4: The rotation rate depends only on the switch byte captured at reset. With increment N and the accumulator starting at zero, the first rotation happens on the add step number ceil(65536/N). Switch moves after reset do not change N.
- R5: On a step with the lockout clear, `leds` is XORed with (previous sample XOR current switches) whenever that mask is nonzero. A switch moving 0 to 1 and a switch moving 1 to 0 both flip their LED.
- R6: A step that applies a change sets the lockout. While the lockout is set, switch changes are not sampled and `leds` changes only through rotation.
- R7: A step that applies a change clears accumulator bits 15:8, keeps bits 7:0, and does not add the increment on that step.
- R8: A rotation clears the lockout. A switch change made during the lockout is compared against the frozen previous sample and is applied on the first step after the rotation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low; captures the rate from `sw` |
| stepEn | input | 1 | Step enable; one game step per edge where this is high |
| sw | input | 8 | Switch byte: rate at reset, game input afterwards |
| leds | output | 8 | Display pattern |

## Verification
The hardest situation to reach from the ports is a switch move made during the lockout, followed by its delayed application on the step right after a rotation. The move has to land hundreds of steps before the rotation, and the accumulator's residue at that point depends on earlier flips. Directed sequences first fill the accumulator, then flip a switch, then flip another one inside the lockout. The bench then steps across the rotation and checks the deferred toggle and the shortened interval. Random runs with sparse switch flips and a gapped `stepEn` are compared every cycle against a step model that the bench computes from the requirements.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  // Per-step strobes issued by the control to the datapath
  typedef struct packed {
    logic sample;    // take the switch byte as the new previous sample
    logic applyChg;  // flip LEDs under changed switches, clear accumulator high half
    logic addStep;   // add increment into the delay accumulator
    logic rotate;    // rotate display left by one
  } rtgStrobes_t;

endpackage

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
#(
  parameter int DISP_W = 8,
  parameter int ACC_W  = 16,
  parameter logic [DISP_W-1:0] DISP_INIT = {{(DISP_W-1){1'b0}}, 1'b1}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DISP_W-1:0] sw,
  input  rtgStrobes_t       strb,
  output logic              chgAny,
  output logic              carryOut,
  output logic [DISP_W-1:0] disp
);

  localparam int HALF  = ACC_W / 2;
  localparam int PAD_W = ACC_W - DISP_W;

  logic [DISP_W-1:0] prevSw;
  logic [DISP_W-1:0] dispQ;
  logic [DISP_W-1:0] chgMask;
  logic [DISP_W-1:0] rotated;
  logic [ACC_W-1:0]  accQ;
  logic [ACC_W-1:0]  incrQ;
  logic [ACC_W:0]    sum;

  assign chgMask  = prevSw ^ sw;
  assign chgAny   = |chgMask;
  assign sum      = {1'b0, accQ} + {1'b0, incrQ};
  assign carryOut = sum[ACC_W];
  assign disp     = dispQ;

  // Left rotation: the top bit wraps into bit 0
  assign rotated[0] = dispQ[DISP_W-1];
  for (genvar i = 1; i < DISP_W; i++) begin : gRot
    assign rotated[i] = dispQ[i-1];
  end

  // Rate increment, captured only under reset
  always_ff @(posedge clk) begin
    if (!rstN) incrQ <= {{PAD_W{1'b0}}, sw};
  end

  // Previous switch sample, frozen while sampling is off
  always_ff @(posedge clk) begin
    if (!rstN)            prevSw <= sw;
    else if (strb.sample) prevSw <= sw;
  end

  // Delay accumulator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (strb.applyChg) begin
      accQ[ACC_W-1:HALF] <= '0;
    end else if (strb.addStep) begin
      accQ <= sum[ACC_W-1:0];
    end
  end

  // Display register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispQ <= DISP_INIT;
    end else if (strb.applyChg) begin
      dispQ <= dispQ ^ chgMask;
    end else if (strb.rotate) begin
      dispQ <= rotated;
    end
  end

endmodule

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stepEn,
  input  logic        chgAny,
  input  logic        carryOut,
  output rtgStrobes_t strb
);

  logic lockQ;

  always_comb begin
    strb.sample   = stepEn && !lockQ;
    strb.applyChg = strb.sample && chgAny;
    strb.addStep  = stepEn && !strb.applyChg;
    strb.rotate   = strb.addStep && carryOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              lockQ <= 1'b0;
    else if (strb.applyChg) lockQ <= 1'b1;
    else if (strb.rotate)   lockQ <= 1'b0;
  end

endmodule

// File: rtl/rot_toggle_game.sv
module rot_toggle_game
  import rtg_pkg::*;
#(
  parameter int DISP_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic [DISP_W-1:0] sw,
  output logic [DISP_W-1:0] leds
);

  rtgStrobes_t strb;
  logic        chgAny;
  logic        carryOut;

  rtg_ctrl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .stepEn   (stepEn),
    .chgAny   (chgAny),
    .carryOut (carryOut),
    .strb     (strb)
  );

  rtg_datapath #(
    .DISP_W (DISP_W),
    .ACC_W  (ACC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sw       (sw),
    .strb     (strb),
    .chgAny   (chgAny),
    .carryOut (carryOut),
    .disp     (leds)
  );

endmodule

// File: rtl/rot_toggle_game_chk.sv
module rot_toggle_game_chk #(
  parameter int DISP_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              stepEn,
  input logic [DISP_W-1:0] leds,
  input logic              lockQ,
  input logic              rotEv,
  input logic              chgEv
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (leds == {{(DISP_W-1){1'b0}}, 1'b1}) && !lockQ);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stepEn |=> $stable(leds) && $stable(lockQ));

  // R3
  rotate_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    rotEv |=> leds == {$past(leds[DISP_W-2:0]), $past(leds[DISP_W-1])});

  // R5
  toggle_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    chgEv |=> leds != $past(leds));

  // R6
  lock_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    chgEv |=> lockQ);

  // R6
  lock_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && lockQ && !rotEv) |=> $stable(leds) && lockQ);

  // R8
  rot_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    rotEv |=> !lockQ);

endmodule

bind rot_toggle_game rot_toggle_game_chk #(.DISP_W(DISP_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .stepEn (stepEn),
  .leds   (leds),
  .lockQ  (u_ctl.lockQ),
  .rotEv  (strb.rotate),
  .chgEv  (strb.applyChg)
);

// File: tb/rot_toggle_game_bench.sv
module rot_toggle_game_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stepEn = 1'b0;
  logic [7:0] sw = 8'h00;
  logic [7:0] leds;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  // Reference step model built from the requirements
  logic [7:0]  mDisp, mPrev;
  logic [15:0] mAcc, mIncr;
  logic        mLock;
  string       evTag;

  rot_toggle_game u_rot_toggle_game (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .sw(sw), .leds(leds)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] rotl(input logic [7:0] v);
    return {v[6:0], v[7]};
  endfunction

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cycles);
      report();
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: leds actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input logic r, input logic en, input logic [7:0] s);
    logic [16:0] tot;
    if (!r) begin
      mDisp = 8'h01; mLock = 0; mAcc = 16'h0; mIncr = {8'h00, s}; mPrev = s; evTag = "R1";
    end else if (!en) begin
      evTag = "R2";
    end else if (!mLock && ((mPrev ^ s) != 8'h00)) begin
      mDisp = mDisp ^ (mPrev ^ s); mPrev = s; mAcc[15:8] = 8'h00; mLock = 1; evTag = "R5";
    end else begin
      evTag = mLock ? "R6" : "R3";
      if (!mLock) mPrev = s;
      tot = {1'b0, mAcc} + {1'b0, mIncr};
      mAcc = tot[15:0];
      if (tot[16]) begin mDisp = rotl(mDisp); mLock = 0; evTag = "R3"; end
    end
  endtask

  // Drive away from the edge, step, then sample a quarter period later
  task automatic cyc(input logic r, input logic en, input logic [7:0] s);
    rstN = r; stepEn = en; sw = s;
    modelStep(r, en, s);
    @(posedge clk); #5;
    check(evTag, leds, mDisp);
  endtask

  task automatic doReset(input logic [7:0] s);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, s);
  endtask

  initial begin
    logic [7:0] cur;
    void'($urandom(32'd4321));
    #3;
    // R1: reset state with fastest rate
    doReset(8'hFF);
    check("R1", leds, 8'h01);

    // R3: first rotation at add step 258 for increment 255
    for (int i = 1; i <= 257; i++) cyc(1'b1, 1'b1, 8'hFF);
    check("R3", leds, 8'h01);
    cyc(1'b1, 1'b1, 8'hFF);
    check("R3", leds, 8'h02);

    // R2: steps disabled, switch moves have no effect
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 8'(i * 37));
    check("R2", leds, 8'h02);
    cyc(1'b1, 1'b0, 8'hFF);

    // R7: fill accumulator, then flip a switch; high half cleared
    for (int i = 0; i < 200; i++) cyc(1'b1, 1'b1, 8'hFF);
    cur = leds;
    cyc(1'b1, 1'b1, 8'hFE);
    check("R5", leds, cur ^ 8'h01);
    cur = leds;
    // R6: a move inside the lockout is ignored
    for (int i = 0; i < 100; i++) cyc(1'b1, 1'b1, 8'hBE);
    check("R6", leds, cur);
    check("R7", leds, cur);
    // R8: run to rotation, then the deferred change lands next step
    while (mLock) cyc(1'b1, 1'b1, 8'hBE);
    check("R8", leds, rotl(cur));
    cyc(1'b1, 1'b1, 8'hBE);
    check("R8", leds, rotl(cur) ^ 8'h40);

    // R4: rate 128 stays fixed although switches then sit at FF
    doReset(8'h80);
    cyc(1'b1, 1'b1, 8'hFF);
    check("R5", leds, 8'h7E);
    for (int i = 0; i < 511; i++) cyc(1'b1, 1'b1, 8'hFF);
    check("R4", leds, 8'h7E);
    cyc(1'b1, 1'b1, 8'hFF);
    check("R4", leds, 8'hFC);

    // Random phases: sparse flips, gapped step enable, two rates
    for (int p = 0; p < 2; p++) begin
      cur = (p == 0) ? 8'hC3 : 8'h5A;
      doReset(cur);
      for (int i = 0; i < 30000; i++) begin
        if ($urandom % 40 == 0) cur = cur ^ (8'h01 << ($urandom % 8));
        cyc(1'b1, ($urandom % 4) != 0, cur);
      end
    end

    done = 1;
    report();
  end

endmodule